// File: doc/BRIEF.md
# Attribute-Space CIS Loader

This block fills an on-chip byte store with the card information structure from a boot EEPROM, and then answers the host's reads of attribute memory from that store. Every hardware reset starts a fresh copy of all 512 bytes, fetched one at a time through a simple request/valid byte port. While the copy runs, the card holds its active-low interrupt-request output low. The host controller reads that as "wait" and stays away until the structure is in place.

The host sees the structure on even attribute addresses only: byte n answers at address 2n, and every odd address reads as the filler value 0xFF. A host read that arrives during the copy also returns 0xFF and does not disturb the copy. Read data is registered, so it appears on the port one clock after the selected address is sampled.

Top module: `cis_attr_loader`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `host_ireq_n` is 0, `ee_req` is 1 and `ee_addr` is 0, so the copy starts at byte 0 without any further stimulus.
- R2: Each EEPROM byte is requested with a one-cycle `ee_req` pulse. `ee_addr` stays stable until `ee_valid` answers, the next request follows only after that answer, and the addresses run 0, 1, ..., 511 in order.
- R3: `host_ireq_n` stays 0 through the cycle in which byte 511 arrives with `ee_valid`. It is 1 on the following cycle and stays 1 until the next reset, and no `ee_req` is issued in that time.
- R4: A host read is selected when `host_reg_n`, `host_oe_n` and `host_ce_n` are all 0. After the copy, a read at even address 2n returns EEPROM byte n on `host_data` one clock after the address is sampled.
- R5: A selected read at an odd address (`host_addr[0]` = 1) returns 0xFF.
- R6: A selected read during the copy returns 0xFF and leaves the copy unchanged: same request sequence, all 512 bytes stored correctly.
- R7: When any of `host_reg_n`, `host_oe_n` or `host_ce_n` is 1, `host_data` is 0xFF on the next cycle.
- R8: `ee_valid` pulses that arrive after the copy has finished are ignored: stored bytes are unchanged.
- R9: Each new reset reruns the full copy, and the new EEPROM contents replace the old.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ee_addr | output | 9 | Index of the EEPROM byte being fetched |
| ee_req | output | 1 | One-cycle fetch request |
| ee_data | input | 8 | Byte returned by the EEPROM |
| ee_valid | input | 1 | `ee_data` is valid for the outstanding request |
| host_reg_n | input | 1 | Attribute/register space select, active low |
| host_oe_n | input | 1 | Output enable, active low |
| host_ce_n | input | 1 | Card enable, active low |
| host_addr | input | 10 | Attribute-memory byte address |
| host_data | output | 8 | Read data, registered |
| host_ireq_n | output | 1 | Busy indication, low while copying |

## Verification
The EEPROM model answers each request after a latency that varies with the address (one to three cycles), so a sequencer that ran ahead of `ee_valid` or skipped an index would store the wrong bytes. Two resets load two different byte patterns. This tells a real rerun of the copy apart from stale contents, and because byte 0 of each pattern differs from 0xFF, a filler read is never mistaken for data. Host reads go to every even address, to odd addresses at both ends of the space, with each enable held high in turn, and during the copy. Stray `ee_valid` pulses after completion show whether the store can be overwritten outside a request.

// File: rtl/cis_ldr_pkg.sv
package cis_ldr_pkg;
   typedef enum logic [1:0] {
      LD_ISSUE = 2'd0,
      LD_WAIT  = 2'd1,
      LD_DONE  = 2'd2
   } ld_state_e;
endpackage

// File: rtl/cis_copy_seq.sv
module cis_copy_seq
   import cis_ldr_pkg::*;
#(
   parameter int NUM_BYTES = 512,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [IDX_W-1:0]  ee_addr,
   output logic              ee_req,
   input  logic [DATA_W-1:0] ee_data,
   input  logic              ee_valid,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

   ld_state_e        state;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= LD_ISSUE;
         idx   <= '0;
      end else begin
         case (state)
            LD_ISSUE: state <= LD_WAIT;
            LD_WAIT: begin
               if (ee_valid) begin
                  if (idx == LAST_IDX) begin
                     state <= LD_DONE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= LD_ISSUE;
                  end
               end
            end
            default: state <= LD_DONE;
         endcase
      end
   end

   always_comb begin
      ee_req  = (state == LD_ISSUE);
      ee_addr = idx;
      wr_en   = (state == LD_WAIT) && ee_valid;
      wr_idx  = idx;
      wr_data = ee_data;
      busy    = (state != LD_DONE);
   end

   // a request lasts exactly one cycle
   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      ee_req |=> !ee_req);
   // the fetch index does not move between request and answer
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (ee_req || (!busy)) |=> $stable(ee_addr));
endmodule

// File: rtl/cis_byte_ram.sv
module cis_byte_ram #(
   parameter int DEPTH   = 512,
   parameter int DATA_W  = 8,
   parameter bit SYNC_RD = 1'b1,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (SYNC_RD) begin : g_sync
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_async
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/cis_attr_port.sv
module cis_attr_port #(
   parameter int              ATTR_AW   = 10,
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] FILL_BYTE = '1,
   parameter bit              SYNC_RD   = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_n,
   input  logic               oe_n,
   input  logic               ce_n,
   input  logic [ATTR_AW-1:0] addr,
   input  logic               loaded,
   output logic [ATTR_AW-2:0] ram_raddr,
   input  logic [DATA_W-1:0]  ram_rdata,
   output logic [DATA_W-1:0]  data
);
   logic sel, hit;

   always_comb begin
      sel       = !reg_n && !oe_n && !ce_n;
      hit       = sel && loaded && !addr[0];
      ram_raddr = addr[ATTR_AW-1:1];
   end

   generate
      if (SYNC_RD) begin : g_sync
         logic hit_q;
         always_ff @(posedge clk) begin
            if (rst) hit_q <= 1'b0;
            else     hit_q <= hit;
         end
         assign data = hit_q ? ram_rdata : FILL_BYTE;

         assert_odd_fill_R5: assert property (@(posedge clk) disable iff (rst)
            (sel && addr[0]) |=> (data == FILL_BYTE));
         assert_busy_fill_R6: assert property (@(posedge clk) disable iff (rst)
            (sel && !loaded) |=> (data == FILL_BYTE));
         assert_idle_fill_R7: assert property (@(posedge clk) disable iff (rst)
            !sel |=> (data == FILL_BYTE));
      end else begin : g_async
         assign data = hit ? ram_rdata : FILL_BYTE;

         assert_odd_fill_R5: assert property (@(posedge clk) disable iff (rst)
            (sel && addr[0]) |-> (data == FILL_BYTE));
         assert_busy_fill_R6: assert property (@(posedge clk) disable iff (rst)
            (sel && !loaded) |-> (data == FILL_BYTE));
         assert_idle_fill_R7: assert property (@(posedge clk) disable iff (rst)
            !sel |-> (data == FILL_BYTE));
      end
   endgenerate
endmodule

// File: rtl/cis_attr_loader.sv
module cis_attr_loader #(
   parameter int                NUM_BYTES = 512,
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] FILL_BYTE = '1,
   parameter bit                SYNC_RD   = 1'b1,
   localparam int               IDX_W     = $clog2(NUM_BYTES),
   localparam int               ATTR_AW   = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst,
   output logic [IDX_W-1:0]   ee_addr,
   output logic               ee_req,
   input  logic [DATA_W-1:0]  ee_data,
   input  logic               ee_valid,
   input  logic               host_reg_n,
   input  logic               host_oe_n,
   input  logic               host_ce_n,
   input  logic [ATTR_AW-1:0] host_addr,
   output logic [DATA_W-1:0]  host_data,
   output logic               host_ireq_n
);
   generate
      if (NUM_BYTES < 2 || (NUM_BYTES & (NUM_BYTES - 1)) != 0) begin : g_bad_depth
         $error("cis_attr_loader: NUM_BYTES must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("cis_attr_loader: DATA_W must be positive");
      end
   endgenerate

   logic              wr_en, busy;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, rd_data;

   cis_copy_seq #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst(rst),
      .ee_addr(ee_addr), .ee_req(ee_req), .ee_data(ee_data), .ee_valid(ee_valid),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy)
   );

   cis_byte_ram #(.DEPTH(NUM_BYTES), .DATA_W(DATA_W), .SYNC_RD(SYNC_RD)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
      .raddr(rd_idx), .rdata(rd_data)
   );

   cis_attr_port #(.ATTR_AW(ATTR_AW), .DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE),
                   .SYNC_RD(SYNC_RD)) u_port (
      .clk(clk), .rst(rst),
      .reg_n(host_reg_n), .oe_n(host_oe_n), .ce_n(host_ce_n), .addr(host_addr),
      .loaded(!busy), .ram_raddr(rd_idx), .ram_rdata(rd_data), .data(host_data)
   );

   assign host_ireq_n = !busy;

   // once released, the busy line stays released until reset
   assert_ireq_hold_R3: assert property (@(posedge clk) disable iff (rst)
      host_ireq_n |=> host_ireq_n);
   // no EEPROM traffic after the copy has ended
   assert_quiet_after_R3: assert property (@(posedge clk) disable iff (rst)
      host_ireq_n |-> !ee_req);
   // a store write only happens while the card still signals busy
   assert_write_busy_R8: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !host_ireq_n);
endmodule

// File: tb/tb_cis_attr_loader.sv
`timescale 1ns/1ps
module tb_cis_attr_loader;
   localparam int NB = 512;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] ee_addr;
   logic       ee_req;
   logic [7:0] ee_data = 8'h00;
   logic       ee_valid = 1'b0;
   logic       host_reg_n = 1'b1, host_oe_n = 1'b1, host_ce_n = 1'b1;
   logic [9:0] host_addr = '0;
   logic [7:0] host_data;
   logic       host_ireq_n;

   always #2.5 clk = ~clk;

   cis_attr_loader dut (
      .clk(clk), .rst(rst), .ee_addr(ee_addr), .ee_req(ee_req),
      .ee_data(ee_data), .ee_valid(ee_valid),
      .host_reg_n(host_reg_n), .host_oe_n(host_oe_n), .host_ce_n(host_ce_n),
      .host_addr(host_addr), .host_data(host_data), .host_ireq_n(host_ireq_n)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int n);
      return 8'((n * 37 + seed) ^ (n >> 3));
   endfunction

   // EEPROM model
   int   seed = 8'h21;
   bit   model_on = 1'b1;
   int   next_exp = 0, order_err = 0, req_err = 0, served = 0;
   bit   last_pending = 0;
   logic last_pre, last_post;

   initial forever begin
      @(negedge clk);
      if (model_on) begin
         ee_valid = 1'b0;
         if (last_pending) begin
            last_post = host_ireq_n;
            last_pending = 0;
         end
         if (!rst && ee_req) begin
            int a;
            a = int'(ee_addr);
            if (a != next_exp) order_err++;
            next_exp = a + 1;
            for (int k = 0; k < 1 + a % 3; k++) begin
               @(negedge clk);
               if (ee_req || int'(ee_addr) != a) req_err++;
            end
            ee_data  = pat(seed, a);
            ee_valid = 1'b1;
            served++;
            if (a == NB - 1) begin
               last_pre = host_ireq_n;
               last_pending = 1;
            end
         end
      end
   end

   task automatic host_read(input logic [9:0] a, input logic rn, input logic on,
                            input logic cn, output logic [7:0] d);
      @(negedge clk);
      host_reg_n = rn; host_oe_n = on; host_ce_n = cn; host_addr = a;
      @(negedge clk);
      d = host_data;
      host_reg_n = 1'b1; host_oe_n = 1'b1; host_ce_n = 1'b1;
   endtask

   task automatic do_reset(input int new_seed);
      seed = new_seed;
      next_exp = 0; order_err = 0; req_err = 0; served = 0;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(host_ireq_n == 1'b0, "R1 busy low in reset", host_ireq_n, 0);
      @(posedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      check(host_ireq_n == 1'b0, "R1 busy low after reset", host_ireq_n, 0);
      check(ee_req == 1'b1 && ee_addr == 9'd0, "R1 first request at byte 0",
            {ee_req, ee_addr}, {1'b1, 9'd0});
   endtask

   task automatic test_read_during_copy();
      logic [7:0] d;
      host_read(10'd0, 0, 0, 0, d);
      check(d == 8'hFF, "R6 read at 0 during copy", d, 8'hFF);
      host_read(10'd2, 0, 0, 0, d);
      check(d == 8'hFF, "R6 read at 2 during copy", d, 8'hFF);
      check(host_ireq_n == 1'b0, "R6 busy still low after reads", host_ireq_n, 0);
   endtask

   task automatic wait_done();
      int n = 0;
      while (host_ireq_n !== 1'b1 && n < 20000) begin
         @(negedge clk); n++;
      end
      @(negedge clk);
      check(served == NB, "R2 bytes fetched", served, NB);
      check(order_err == 0, "R2 ascending addresses", order_err, 0);
      check(req_err == 0, "R2 one pulse, address held until answer", req_err, 0);
      check(last_pre == 1'b0, "R3 busy low on last byte cycle", last_pre, 0);
      check(last_post == 1'b1, "R3 busy released next cycle", last_post, 1);
   endtask

   task automatic test_quiet_after();
      int reqs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ee_req) reqs++;
         if (!host_ireq_n) reqs++;
      end
      check(reqs == 0, "R3 no requests and busy stays high", reqs, 0);
   endtask

   task automatic test_full_read(input string tag);
      logic [7:0] d;
      int errs = 0;
      for (int n = 0; n < NB; n++) begin
         host_read(10'(2 * n), 0, 0, 0, d);
         if (d != pat(seed, n)) begin
            errs++;
            check(0, tag, d, pat(seed, n));
         end
      end
      check(errs == 0, tag, errs, 0);
   endtask

   task automatic test_odd();
      logic [7:0] d;
      host_read(10'd1, 0, 0, 0, d);     check(d == 8'hFF, "R5 odd 0x001", d, 8'hFF);
      host_read(10'd3, 0, 0, 0, d);     check(d == 8'hFF, "R5 odd 0x003", d, 8'hFF);
      host_read(10'h201, 0, 0, 0, d);   check(d == 8'hFF, "R5 odd 0x201", d, 8'hFF);
      host_read(10'h3FF, 0, 0, 0, d);   check(d == 8'hFF, "R5 odd 0x3FF", d, 8'hFF);
      host_read(10'h3FE, 0, 0, 0, d);
      check(d == pat(seed, 511), "R4 even 0x3FE", d, pat(seed, 511));
   endtask

   task automatic test_unselected();
      logic [7:0] d;
      host_read(10'd0, 1, 0, 0, d);  check(d == 8'hFF, "R7 reg high", d, 8'hFF);
      host_read(10'd0, 0, 1, 0, d);  check(d == 8'hFF, "R7 oe high", d, 8'hFF);
      host_read(10'd0, 0, 0, 1, d);  check(d == 8'hFF, "R7 ce high", d, 8'hFF);
      host_read(10'd0, 0, 0, 0, d);
      check(d == pat(seed, 0), "R4 selected at 0", d, pat(seed, 0));
   endtask

   task automatic test_stray_valid();
      logic [7:0] d;
      model_on = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         ee_data = 8'h00; ee_valid = 1'b1;
      end
      @(negedge clk);
      ee_valid = 1'b0;
      model_on = 1'b1;
      host_read(10'd0, 0, 0, 0, d);
      check(d == pat(seed, 0), "R8 byte 0 unchanged", d, pat(seed, 0));
      host_read(10'd2, 0, 0, 0, d);
      check(d == pat(seed, 1), "R8 byte 1 unchanged", d, pat(seed, 1));
      host_read(10'h3FE, 0, 0, 0, d);
      check(d == pat(seed, 511), "R8 byte 511 unchanged", d, pat(seed, 511));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset(8'h21);
      test_read_during_copy();
      wait_done();
      test_quiet_after();
      test_full_read("R4 even read, first load");
      test_odd();
      test_unselected();
      test_stray_valid();
      do_reset(8'h5A);
      wait_done();
      test_full_read("R9 contents after second reset");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule